// File: doc/BRIEF.md
# Iterative Multi-Digit Decimal Multiplier

This block multiplies two unsigned decimal integers held as packed BCD, each `NDIG` digits wide, and returns the full `2*NDIG`-digit BCD product. It works one multiplier digit per clock. In each step a bank of `NDIG` single-digit multipliers forms the product of that digit with the whole multiplicand. The bank's two-digit results are aligned and summed into one partial product, which a second stage adds into a decimal running sum. After each addition the running sum moves down one decimal place, and the digit that leaves the bottom becomes the next product digit.

The two stages form a short pipeline. The accumulation of an operation's last partial product takes place in the same cycle as the first partial-product step of the operation behind it. A caller holding `in_valid` high can therefore start a new multiply every `NDIG` cycles, and each result still appears `NDIG+1` cycles after its operands were taken. Signs, exponents and rounding belong to the caller.

Top module: `bcd_iter_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` holds the exact product of the accepted operands as `2*NDIG` BCD digits, digit k in bits [4k+3:4k]. Digit 0 is the least significant and every digit is 0 to 9. Operands use the same packing with `NDIG` digits.
- R2: `out_valid` rises exactly `NDIG+1` clock edges after the edge at which the operands were accepted (`in_valid` and `in_ready` both high).
- R3: `in_ready` is high when no operation is generating partial products, and during the last generation step (step `NDIG-1`) of the current operation. It is low in every other cycle, so consecutive accepts are at least `NDIG` edges apart.
- R4: `out_valid` is a single-cycle pulse, issued exactly once for each accepted operation and at no other time.
- R5: A synchronous active-high `rst` discards any operation in flight. After the reset edge `out_valid` is low and `in_ready` is high, and no result for a discarded operation ever appears.
- R6: An `in_valid` presented while `in_ready` is low is ignored. The operands on the bus in those cycles do not change the result of the operation in progress, and they do not start an operation.
- R7: With `in_valid` held high, operations are accepted every `NDIG` cycles and each result is correct. The last accumulation of one operation overlaps the first partial-product step of the next.
- R8: Boundary operands give exact results. For example, all-nines times all-nines gives `NDIG-1` nines, an 8, `NDIG-1` zeros and a 1, and a zero operand gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the input buses are offered |
| in_ready | output | 1 | An offered operand pair is taken at this edge |
| in_mcand | input | 4*NDIG | Multiplicand, packed BCD |
| in_mplier | input | 4*NDIG | Multiplier, packed BCD, consumed least significant digit first |
| out_valid | output | 1 | One-cycle pulse: `out_prod` is valid |
| out_prod | output | 8*NDIG | Product, packed BCD |

## Verification
A wrong step count or a missed last-step flag shows at the ports within one operation. Either `in_ready` opens a cycle early or late, or `out_valid` misses the `NDIG+1` slot, and the bench's cycle model flags both at the next sampling point. A bad decimal correction or a misaligned partial product corrupts the product digits of the first multiply that uses the affected digit pair. The bench therefore runs random operands on every digit position and the all-nines case, where every carry chain is live. Overlap faults show up only under back-to-back traffic, as a first step that reads stale sum bits, so long runs with `in_valid` held high compare every pulse against an independent integer model.

// File: rtl/bcd_mul_pkg.sv
package bcd_mul_pkg;

  // product of two BCD digits as two BCD digits {tens, units}
  function automatic logic [7:0] digit_mul(input logic [3:0] a, input logic [3:0] b);
    logic [6:0] p;
    p = 7'(a) * 7'(b);
    return {4'(p / 7'd10), 4'(p % 7'd10)};
  endfunction

  // one decimal digit add with carry in; returns {carry, digit}
  function automatic logic [4:0] digit_add(input logic [3:0] a, input logic [3:0] b,
                                           input logic cin);
    logic [4:0] t;
    t = 5'(a) + 5'(b) + 5'(cin);
    if (t > 5'd9) t = t + 5'd6;
    return t;
  endfunction

endpackage

// File: rtl/bcd_adder.sv
module bcd_adder #(
  parameter int NDIG = 8
) (
  input  logic [4*NDIG-1:0] a,
  input  logic [4*NDIG-1:0] b,
  output logic [4*NDIG-1:0] sum,
  output logic              cout
);
  import bcd_mul_pkg::*;

  logic [NDIG:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [4:0] t;
    assign t              = digit_add(a[4*i +: 4], b[4*i +: 4], carry[i]);
    assign sum[4*i +: 4]  = t[3:0];
    assign carry[i+1]     = t[4];
  end

  assign cout = carry[NDIG];
endmodule

// File: rtl/bcd_pp_gen.sv
module bcd_pp_gen #(
  parameter int NDIG = 7,
  localparam int PPW = 4 * (NDIG + 1)
) (
  input  logic [4*NDIG-1:0] mcand,
  input  logic [3:0]        digit,
  output logic [PPW-1:0]    pp,
  output logic              pp_cout
);
  import bcd_mul_pkg::*;

  logic [4*NDIG-1:0] units_vec;
  logic [4*NDIG-1:0] tens_vec;

  for (genvar i = 0; i < NDIG; i++) begin : g_mul
    logic [7:0] dp;
    assign dp                  = digit_mul(mcand[4*i +: 4], digit);
    assign units_vec[4*i +: 4] = dp[3:0];
    assign tens_vec[4*i +: 4]  = dp[7:4];
  end

  // tens of digit i weigh one place more than units of digit i
  bcd_adder #(.NDIG(NDIG + 1)) u_sum (
    .a    ({4'h0, units_vec}),
    .b    ({tens_vec, 4'h0}),
    .sum  (pp),
    .cout (pp_cout)
  );
endmodule

// File: rtl/bcd_accum.sv
module bcd_accum #(
  parameter int NDIG = 7,
  localparam int PPW = 4 * (NDIG + 1),
  localparam int HW  = 4 * NDIG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pp_v,
  input  logic            pp_first,
  input  logic            pp_last,
  input  logic [PPW-1:0]  pp,
  output logic            prod_v,
  output logic [2*HW-1:0] prod_q
);
  logic [HW-1:0]  upper_q;
  logic [HW-1:0]  lower_q;
  logic [PPW-1:0] addend;
  logic [PPW-1:0] step_sum;
  logic           acc_cout;

  assign addend = pp_first ? '0 : {4'h0, upper_q};

  bcd_adder #(.NDIG(NDIG + 1)) u_acc (
    .a    (addend),
    .b    (pp),
    .sum  (step_sum),
    .cout (acc_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      lower_q <= '0;
      prod_v  <= 1'b0;
      prod_q  <= '0;
    end else begin
      prod_v <= pp_v && pp_last;
      if (pp_v) begin
        upper_q <= step_sum[PPW-1:4];
        lower_q <= {step_sum[3:0], lower_q[HW-1:4]};
        if (pp_last)
          prod_q <= {step_sum[PPW-1:4], step_sum[3:0], lower_q[HW-1:4]};
      end
    end
  end

  // running sum never exceeds NDIG+1 digits
  p_acc_fits_r1: assert property (@(posedge clk) disable iff (rst) pp_v |-> !acc_cout);
  // the last accumulation is what raises the result strobe
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (pp_v && pp_last) |=> prod_v);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst) prod_v |=> !prod_v);
  for (genvar d = 0; d < 2*NDIG; d++) begin : g_chk
    p_digit_bcd_r1: assert property (@(posedge clk) disable iff (rst)
      prod_v |-> (prod_q[4*d +: 4] <= 4'd9));
  end
endmodule

// File: rtl/bcd_iter_mul.sv
module bcd_iter_mul #(
  parameter int NDIG = 7,
  localparam int HW  = 4 * NDIG,
  localparam int PPW = 4 * (NDIG + 1),
  localparam int CW  = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HW-1:0]   in_mcand,
  input  logic [HW-1:0]   in_mplier,
  output logic            out_valid,
  output logic [2*HW-1:0] out_prod
);
  // generation stage state
  logic [HW-1:0]  mcand_q;
  logic [HW-1:0]  mplier_q;
  logic [CW-1:0]  step_q;
  logic           gen_busy;
  logic           gen_last;
  logic           accept;
  // partial product pipeline register
  logic [PPW-1:0] pp_w;
  logic           pp_cout;
  logic [PPW-1:0] pp_q;
  logic           pp_v_q;
  logic           pp_first_q;
  logic           pp_last_q;

  assign gen_last = gen_busy && (step_q == CW'(NDIG - 1));
  assign in_ready = !gen_busy || gen_last;
  assign accept   = in_valid && in_ready;

  bcd_pp_gen #(.NDIG(NDIG)) u_ppgen (
    .mcand   (mcand_q),
    .digit   (mplier_q[3:0]),
    .pp      (pp_w),
    .pp_cout (pp_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_busy <= 1'b0;
      step_q   <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (accept) begin
      gen_busy <= 1'b1;
      step_q   <= '0;
      mcand_q  <= in_mcand;
      mplier_q <= in_mplier;
    end else if (gen_last) begin
      gen_busy <= 1'b0;
    end else if (gen_busy) begin
      step_q   <= step_q + CW'(1);
      mplier_q <= mplier_q >> 4;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_v_q     <= 1'b0;
      pp_first_q <= 1'b0;
      pp_last_q  <= 1'b0;
      pp_q       <= '0;
    end else begin
      pp_v_q     <= gen_busy;
      pp_first_q <= gen_busy && (step_q == '0);
      pp_last_q  <= gen_last;
      pp_q       <= pp_w;
    end
  end

  bcd_accum #(.NDIG(NDIG)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .pp_v     (pp_v_q),
    .pp_first (pp_first_q),
    .pp_last  (pp_last_q),
    .pp       (pp_q),
    .prod_v   (out_valid),
    .prod_q   (out_prod)
  );

  // a digit times the multiplicand fits in NDIG+1 digits
  p_pp_fits_r1: assert property (@(posedge clk) disable iff (rst) gen_busy |-> !pp_cout);
  // an operation keeps stepping until its last digit
  p_no_early_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (gen_busy && !gen_last) |=> (gen_busy && step_q == $past(step_q) + CW'(1)));
  p_accept_starts_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (gen_busy && step_q == '0));
  p_last_reaches_acc_r2: assert property (@(posedge clk) disable iff (rst)
    gen_last |=> (pp_v_q && pp_last_q));
endmodule

// File: tb/bcd_iter_mul_test.sv
`timescale 1ns/1ps
module bcd_iter_mul_test;
  localparam int N = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [4*N-1:0] in_mcand = '0;
  logic [4*N-1:0] in_mplier = '0;
  logic           out_valid;
  logic [8*N-1:0] out_prod;

  int n_checks = 0;
  int n_fail   = 0;
  longint cyc  = 0;
  int rem      = 0;
  longint         due_q[$];
  logic [8*N-1:0] exp_q[$];

  always #2 clk = ~clk;

  bcd_iter_mul #(.NDIG(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplier(in_mplier),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic longint to_int(input logic [4*N-1:0] v);
    longint x = 0;
    for (int k = N - 1; k >= 0; k--) x = x * 10 + longint'(v[4*k +: 4]);
    return x;
  endfunction

  function automatic logic [8*N-1:0] to_bcd(input longint x);
    logic [8*N-1:0] r = '0;
    for (int k = 0; k < 2*N; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [4*N-1:0] rnd_bcd();
    logic [4*N-1:0] r;
    for (int k = 0; k < N; k++) r[4*k +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  // one clock: check outputs against the model, then drive the next inputs
  task automatic step(input bit v, input bit r, input logic [4*N-1:0] a,
                      input logic [4*N-1:0] b, input string tag);
    bit exp_v;
    bit exp_rdy;
    @(negedge clk);
    exp_v   = (due_q.size() > 0) && (due_q[0] == cyc - 1);
    exp_rdy = (rem <= 1);
    n_checks++;
    if (out_valid !== exp_v) begin
      n_fail++;
      $display("FAIL %s R2/R4 out_valid cycle %0d: got %b expected %b", tag, cyc, out_valid, exp_v);
    end
    if (exp_v) begin
      n_checks++;
      if (out_prod !== exp_q[0]) begin
        n_fail++;
        $display("FAIL %s R1 product: got %h expected %h", tag, out_prod, exp_q[0]);
      end
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
    end
    n_checks++;
    if (in_ready !== exp_rdy) begin
      n_fail++;
      $display("FAIL %s R3 in_ready cycle %0d: got %b expected %b", tag, cyc, in_ready, exp_rdy);
    end
    rst       = r;
    in_valid  = v;
    in_mcand  = a;
    in_mplier = b;
    if (r) begin
      due_q.delete();
      exp_q.delete();
      rem = 0;
    end else if (v && rem <= 1) begin
      due_q.push_back(cyc + N + 1);
      exp_q.push_back(to_bcd(to_int(a) * to_int(b)));
      rem = N;
    end else if (rem > 0) begin
      rem--;
    end
    cyc++;
  endtask

  task automatic one_op(input logic [4*N-1:0] a, input logic [4*N-1:0] b, input string tag);
    step(1'b1, 1'b0, a, b, tag);
    for (int k = 0; k < N + 2; k++) step(1'b0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    cyc = 3;
    // R5: state after reset, single idle checks
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, '0, '0, "R5");
    // R1: isolated operations with gaps
    one_op(28'h0000123, 28'h0000456, "R1");
    for (int k = 0; k < 6; k++) one_op(rnd_bcd(), rnd_bcd(), "R1");
    // R8: boundary operands
    one_op({N{4'h9}}, {N{4'h9}}, "R8");
    one_op('0, rnd_bcd(), "R8");
    one_op(rnd_bcd(), '0, "R8");
    one_op({N{4'h9}}, 28'h1, "R8");
    one_op(28'h1, 28'h1, "R8");
    // R7: back-to-back, valid held high with fresh operands each cycle (R6)
    for (int k = 0; k < 40 * N; k++) step(1'b1, 1'b0, rnd_bcd(), rnd_bcd(), "R7");
    for (int k = 0; k < N + 2; k++) step(1'b0, 1'b0, '0, '0, "R7");
    // R6: busy bus noise with all-nines and zeros between accepts
    step(1'b1, 1'b0, 28'h0003141, 28'h0002718, "R6");
    for (int k = 0; k < N - 2; k++)
      step(1'b1, 1'b0, (k % 2) ? '0 : {N{4'h9}}, {N{4'h9}}, "R6");
    for (int k = 0; k < N + 3; k++) step(1'b0, 1'b0, '0, '0, "R6");
    // R5: reset in the middle of an operation
    step(1'b1, 1'b0, rnd_bcd(), rnd_bcd(), "R5");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, '0, '0, "R5");
    step(1'b0, 1'b1, '0, '0, "R5");
    for (int k = 0; k < N + 4; k++) step(1'b0, 1'b0, '0, '0, "R5");
    one_op(rnd_bcd(), rnd_bcd(), "R5");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 run did not finish: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule